// File: doc/BRIEF.md
# Channel-List Sequenced ADC Front End

This block sequences conversions for a 16-input sampling ADC on behalf of a host that talks to it over a small 16-bit register bus. The host loads a channel list of up to 16 entries. Each entry names an input channel, a gain code, a polarity and single-ended or differential operation. Every conversion takes the next entry of the list and wraps back to the first entry after the last one. The 12-bit two's-complement results collect in a 32-deep sample FIFO, which the host drains through the data register.

A conversion is started in one of three ways: by a read of the mode register (software mode), by a pulse on the scan input, which runs through the whole list once (scan mode), or by a chosen edge of an external trigger (external mode). The converter itself lies outside the block. It is driven through a start/done handshake, and the selection of the current entry is held on the converter outputs while a conversion is in flight. Interrupt events are latched in the status register and cleared by any write to it. The interrupt output is these latched events gated by a master enable.

Clearing either enable bit in the enable register empties both the channel list and the sample FIFO. Setting both bits again puts the storage back in service.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status register reads 0x0004 (only the sample-FIFO empty bit, bit 2, set), `irq` is low and no conversion is started.
- R2: For each conversion the converter outputs carry the fields of the channel-list entry: entry bit 7 on `conv_diff`, bit 6 on `conv_unipolar`, bits 5:4 on `conv_gain` and bits 3:0 on `conv_chan`. These outputs are held stable until `conv_done`.
- R3: The mode field is mode-register bits 1:0, with 0 = off, 1 = software, 2 = scan and 3 = external. In software mode a bus read of the mode register (address 0) starts exactly one conversion. In any other mode such a read starts none.
- R4: Successive conversions use the channel-list entries in write order and wrap to entry 0 after the last stored entry.
- R5: In scan mode a one-cycle pulse on `scan_trig` converts every list entry once, starting from the current position. When the pass ends, status bit 10 is latched if mode-register bit 10 is set.
- R6: In external mode, a rising edge of `ext_trig` starts one conversion when mode-register bit 3 is 0, and a falling edge does so when bit 3 is 1. The other edge starts nothing.
- R7: An entry with the differential bit set and either a channel above 7 or the unipolar bit set is skipped with no conversion. The skip sets sticky status bit 6.
- R8: A read of the data register (address 3) pops the oldest sample, sign-extended to 16 bits. A read while the FIFO is empty returns 0.
- R9: Status bit 4 = sample FIFO full (32), bit 3 = at least 16 samples, bit 2 = empty, bit 1 = channel list full (16 entries).
- R10: A result that arrives while the sample FIFO is full is dropped, and the drop sets sticky status bit 5.
- R11: While enable-register (address 1) bit 10 or bit 9 is 0, the channel list and the sample FIFO are empty and the list position returns to entry 0.
- R12: Any write to the status register (address 2) clears bits 5, 6, 8, 9 and 10. `irq` is high exactly when mode-register bit 15 is set and one of status bits 8 to 10 is set.
- R13: When the sample count rises to 16 and mode-register bit 8 is set, status bit 8 is latched.
- R14: When mode-register bit 9 is set, a selected edge of `ext_trig` latches status bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 mode, 1 enable, 2 status, 3 data/list |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data appears one cycle later |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| scan_trig | input | 1 | Scan start pulse (scan mode) |
| ext_trig | input | 1 | External trigger level, synchronous to clk |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | 4 | Selected input channel |
| conv_gain | output | 2 | Selected gain code |
| conv_unipolar | output | 1 | Unipolar range selected |
| conv_diff | output | 1 | Differential input selected |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result, two's complement |
| irq | output | 1 | Interrupt request |

## Verification
A wrong list position shows at the converter outputs on the very next start pulse, because the channel and gain fields no longer match the entry the host expects. A wrong FIFO pointer or count shows in the first data-register read that follows, as a sample out of order or with the wrong sign. It also shows at once in the full, half-full or empty status bits. Faults in flag latching or clearing are visible on `irq` and in the status word the cycle after the event or the status write. The flush and skip paths are checked by the conversions that do or do not start after the triggers that follow.

// File: rtl/adc_seq_pkg.sv
// Shared types and register layout for the ADC sequencer.
// Assumes a 16-bit register bus with word addresses 0..3.
package adc_seq_pkg;

    // One channel-list entry; bit layout is decoded by the engine
    typedef struct packed {
        logic       diff;
        logic       uni;
        logic [1:0] gain;
        logic [3:0] chan;
    } cl_entry_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SW   = 2'd1,
        MODE_SCAN = 2'd2,
        MODE_EXT  = 2'd3
    } trig_mode_t;

    localparam logic [1:0] A_MODE   = 2'd0;
    localparam logic [1:0] A_ENABLE = 2'd1;
    localparam logic [1:0] A_STATUS = 2'd2;
    localparam logic [1:0] A_DATA   = 2'd3;

    // mode register bits
    localparam int M_EDGE_FALL = 3;
    localparam int M_HF_IE     = 8;
    localparam int M_EXT_IE    = 9;
    localparam int M_RDY_IE    = 10;
    localparam int M_INT_EN    = 15;

    // enable register bits
    localparam int E_FIFO_EN   = 10;
    localparam int E_LIST_EN   = 9;

endpackage

// File: rtl/adc_sample_fifo.sv
// Synchronous sample FIFO. Push when full is ignored (the caller flags it);
// pop when empty is ignored. Flush holds it empty.
module adc_sample_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    // pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/adc_chanlist.sv
// Channel-list store with random-index read. Entries are appended in order;
// appends when full are ignored. Flush empties it.
module adc_chanlist #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     wr,
    input  adc_seq_pkg::cl_entry_t   wentry,
    input  logic [AW-1:0]            ridx,
    output adc_seq_pkg::cl_entry_t   rentry,
    output logic [CW-1:0]            count,
    output logic                     full
);
    adc_seq_pkg::cl_entry_t ent [DEPTH];

    assign full   = (count == CW'(DEPTH));
    assign rentry = ent[ridx];

    // append entries and track fill level
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else if (wr && !full) begin
            count <= count + 1'b1;
        end
    end

    // storage write
    always_ff @(posedge clk) begin
        if (wr && !full && !flush) ent[count[AW-1:0]] <= wentry;
    end
endmodule

// File: rtl/adc_seq_engine.sv
// Conversion sequencer. Takes one list entry per trigger (or every entry for
// a scan), skips invalid differential entries, drives the converter handshake
// and hands results back. Triggers that arrive while busy are dropped.
module adc_seq_engine #(
    parameter int SAMPLE_W   = 12,
    parameter int LIST_DEPTH = 16,
    localparam int AW        = $clog2(LIST_DEPTH),
    localparam int CW        = AW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [CW-1:0]          list_cnt,
    input  adc_seq_pkg::cl_entry_t entry,
    output logic [AW-1:0]          ptr,
    input  logic                   trig_one,
    input  logic                   scan_go,
    output logic                   conv_start,
    output adc_seq_pkg::cl_entry_t sel,
    input  logic                   conv_done,
    input  logic [SAMPLE_W-1:0]    conv_data,
    output logic                   res_valid,
    output logic [SAMPLE_W-1:0]    res_data,
    output logic                   bad_pulse,
    output logic                   pass_done,
    output logic                   active
);
    typedef enum logic { ST_IDLE, ST_CONV } st_t;

    st_t           state;
    logic [CW-1:0] scan_left;
    logic          last_of_pass;
    logic          load_scan, issue, entry_ok;

    // decide whether this cycle loads a scan or consumes an entry
    always_comb begin
        entry_ok  = !(entry.diff && (entry.chan[3] || entry.uni));
        load_scan = (state == ST_IDLE) && !flush && (list_cnt != '0) &&
                    (scan_left == '0) && scan_go;
        issue     = (state == ST_IDLE) && !flush && (list_cnt != '0) &&
                    !load_scan && ((scan_left != '0) || trig_one);
    end

    assign res_valid = (state == ST_CONV) && conv_done;
    assign res_data  = conv_data;
    assign bad_pulse = issue && !entry_ok;
    assign pass_done = (res_valid && last_of_pass) ||
                       (bad_pulse && (scan_left == CW'(1)));
    assign active    = (state == ST_CONV) || (scan_left != '0);

    // sequencer state, list position and converter start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            ptr          <= '0;
            scan_left    <= '0;
            last_of_pass <= 1'b0;
            conv_start   <= 1'b0;
            sel          <= '0;
        end else begin
            conv_start <= 1'b0;
            if (flush) begin
                ptr       <= '0;
                scan_left <= '0;
            end
            if (load_scan) scan_left <= list_cnt;
            if (issue) begin
                ptr <= ({1'b0, ptr} == list_cnt - 1'b1) ? '0 : ptr + 1'b1;
                if (scan_left != '0) scan_left <= scan_left - 1'b1;
                if (entry_ok) begin
                    sel          <= entry;
                    conv_start   <= 1'b1;
                    state        <= ST_CONV;
                    last_of_pass <= (scan_left == CW'(1));
                end
            end
            if (res_valid) begin
                state        <= ST_IDLE;
                last_of_pass <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: register file, trigger qualification, status and interrupt latching
// around the channel list, sequencer and sample FIFO. Assumes ext_trig and
// scan_trig are already synchronous to clk.
module adc_seq_ctrl #(
    parameter int REG_W      = 16,
    parameter int SAMPLE_W   = 12,
    parameter int LIST_DEPTH = 16,
    parameter int FIFO_DEPTH = 32,
    localparam int LAW       = $clog2(LIST_DEPTH),
    localparam int LCW       = LAW + 1,
    localparam int FCW       = $clog2(FIFO_DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic                scan_trig,
    input  logic                ext_trig,
    output logic                conv_start,
    output logic [3:0]          conv_chan,
    output logic [1:0]          conv_gain,
    output logic                conv_unipolar,
    output logic                conv_diff,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                irq
);
    import adc_seq_pkg::*;

    logic [REG_W-1:0] mode_q, en_q;
    trig_mode_t       mode;
    logic             flush;
    logic             ext_q, ext_edge, trig_one, scan_go;
    logic             ovf_q, bad_q, irq_hf_q, irq_ext_q, irq_rdy_q, hf_q;
    logic             stat_wr;

    cl_entry_t        list_entry, sel;
    logic [LAW-1:0]   ptr;
    logic [LCW-1:0]   list_cnt;
    logic             list_full;

    logic             res_valid, bad_pulse, pass_done, active;
    logic [SAMPLE_W-1:0] res_data, fifo_head;
    logic [FCW-1:0]   fifo_cnt;
    logic             fifo_full, fifo_empty, fifo_pop, half;
    logic [REG_W-1:0] status;

    assign mode     = trig_mode_t'(mode_q[1:0]);
    assign flush    = !(en_q[E_FIFO_EN] && en_q[E_LIST_EN]);
    assign stat_wr  = bus_wr && (bus_addr == A_STATUS);
    assign ext_edge = mode_q[M_EDGE_FALL] ? (ext_q && !ext_trig) : (!ext_q && ext_trig);
    assign trig_one = ((mode == MODE_SW) && bus_rd && (bus_addr == A_MODE)) ||
                      ((mode == MODE_EXT) && ext_edge);
    assign scan_go  = (mode == MODE_SCAN) && scan_trig;
    assign fifo_pop = bus_rd && (bus_addr == A_DATA);
    assign half     = (fifo_cnt >= FCW'(FIFO_DEPTH / 2));

    assign conv_chan     = sel.chan;
    assign conv_gain     = sel.gain;
    assign conv_unipolar = sel.uni;
    assign conv_diff     = sel.diff;
    assign irq = mode_q[M_INT_EN] && (irq_hf_q || irq_ext_q || irq_rdy_q);

    adc_chanlist #(.DEPTH(LIST_DEPTH)) u_list (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr(bus_wr && (bus_addr == A_DATA)),
        .wentry(cl_entry_t'(bus_wdata[7:0])),
        .ridx(ptr), .rentry(list_entry),
        .count(list_cnt), .full(list_full)
    );

    adc_seq_engine #(.SAMPLE_W(SAMPLE_W), .LIST_DEPTH(LIST_DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .list_cnt(list_cnt), .entry(list_entry), .ptr(ptr),
        .trig_one(trig_one), .scan_go(scan_go),
        .conv_start(conv_start), .sel(sel),
        .conv_done(conv_done), .conv_data(conv_data),
        .res_valid(res_valid), .res_data(res_data),
        .bad_pulse(bad_pulse), .pass_done(pass_done), .active(active)
    );

    adc_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(res_valid), .din(res_data), .pop(fifo_pop),
        .head(fifo_head), .count(fifo_cnt),
        .full(fifo_full), .empty(fifo_empty)
    );

    // status word assembly
    always_comb begin
        status     = '0;
        status[0]  = active;
        status[1]  = list_full;
        status[2]  = fifo_empty;
        status[3]  = half;
        status[4]  = fifo_full;
        status[5]  = ovf_q;
        status[6]  = bad_q;
        status[8]  = irq_hf_q;
        status[9]  = irq_ext_q;
        status[10] = irq_rdy_q;
    end

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            en_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE)   mode_q <= bus_wdata;
            if (bus_addr == A_ENABLE) en_q   <= bus_wdata;
        end
    end

    // sticky flags and interrupt latches; a status write clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0; bad_q <= 1'b0;
            irq_hf_q <= 1'b0; irq_ext_q <= 1'b0; irq_rdy_q <= 1'b0;
            hf_q <= 1'b0; ext_q <= 1'b0;
        end else begin
            hf_q  <= half;
            ext_q <= ext_trig;
            if (stat_wr) begin
                ovf_q <= 1'b0; bad_q <= 1'b0;
                irq_hf_q <= 1'b0; irq_ext_q <= 1'b0; irq_rdy_q <= 1'b0;
            end else begin
                if (res_valid && fifo_full && !flush)   ovf_q     <= 1'b1;
                if (bad_pulse)                          bad_q     <= 1'b1;
                if (half && !hf_q && mode_q[M_HF_IE])   irq_hf_q  <= 1'b1;
                if (ext_edge && mode_q[M_EXT_IE])       irq_ext_q <= 1'b1;
                if (pass_done && mode_q[M_RDY_IE])      irq_rdy_q <= 1'b1;
            end
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                A_MODE:   bus_rdata <= mode_q;
                A_ENABLE: bus_rdata <= en_q;
                A_STATUS: bus_rdata <= status;
                default:  bus_rdata <= fifo_empty ? '0 :
                             {{(REG_W - SAMPLE_W){fifo_head[SAMPLE_W-1]}}, fifo_head};
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker for adc_seq_ctrl; attached by the bind at the end.
module adc_seq_ctrl_chk #(
    parameter int FIFO_DEPTH = 32,
    parameter int FCW        = 6,
    parameter int LCW        = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           conv_start,
    input logic [3:0]     conv_chan,
    input logic [1:0]     conv_gain,
    input logic           conv_unipolar,
    input logic           conv_diff,
    input logic           conv_done,
    input logic           irq,
    input logic           int_en,
    input logic           flush,
    input logic [FCW-1:0] fifo_cnt,
    input logic [LCW-1:0] list_cnt,
    input logic           fifo_full,
    input logic           fifo_empty,
    input logic           res_valid
);
    // R3: each start is a single-cycle pulse
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2: selection held while the converter works
    p_sel_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_start && !conv_done && !$past(conv_done)) |->
            $stable({conv_chan, conv_gain, conv_unipolar, conv_diff}));

    // R7: no conversion ever starts on an invalid differential entry
    p_no_bad_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !(conv_diff && (conv_chan[3] || conv_unipolar)));

    // R10: sample count never exceeds the depth, and a result into a full FIFO is dropped
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && res_valid) |=> (fifo_cnt <= FCW'(FIFO_DEPTH)));

    // R9: empty and full never together
    p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R11: while disabled both stores stay empty
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_cnt == '0 && list_cnt == '0));

    // R12: irq requires the master enable
    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_en);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .FIFO_DEPTH(FIFO_DEPTH), .FCW(FCW), .LCW(LCW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_gain(conv_gain),
    .conv_unipolar(conv_unipolar), .conv_diff(conv_diff),
    .conv_done(conv_done), .irq(irq), .int_en(mode_q[15]),
    .flush(flush), .fifo_cnt(fifo_cnt), .list_cnt(list_cnt),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .res_valid(res_valid)
);

// File: tb/tb_adc_seq_ctrl.sv
// Scoreboard bench: trigger tasks push the expected entry and sample, a
// start monitor and the FIFO read task pop and compare.
module tb_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        scan_trig = 1'b0, ext_trig = 1'b0;
    logic        conv_start, conv_unipolar, conv_diff, irq;
    logic [3:0]  conv_chan;
    logic [1:0]  conv_gain;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;

    int checks = 0, errors = 0, starts = 0;
    bit finished = 0;
    logic [7:0]  sel_q [$];
    logic [15:0] smp_q [$];

    always #2 clk = ~clk;

    adc_seq_ctrl dut (.*);

    function automatic logic [11:0] pat(input logic [7:0] e);
        return {e[3:0], e[5:4], e[6], e[7], 4'hA};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // converter model: result three cycles after start
    int pend = 0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) pend <= 3;
        else if (pend != 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                conv_done <= 1'b1;
                conv_data <= pat({conv_diff, conv_unipolar, conv_gain, conv_chan});
            end
        end
    end

    // start monitor (R2, R4): compares selection with the expected entry
    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            starts++;
            if (sel_q.size() == 0) chk("R2 unexpected start", {8'h0, conv_diff, conv_unipolar, conv_gain, conv_chan}, 16'hFFFF);
            else chk("R2/R4 entry", {8'h0, conv_diff, conv_unipolar, conv_gain, conv_chan}, {8'h0, sel_q.pop_front()});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic expect_conv(input logic [7:0] e);
        sel_q.push_back(e);
        smp_q.push_back({{4{pat(e)[11]}}, pat(e)});
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic soft_trig();
        logic [15:0] d;
        rd(2'd0, d);
        settle();
    endtask

    task automatic drain(input int n);
        logic [15:0] d;
        for (int i = 0; i < n; i++) begin
            rd(2'd3, d);
            chk("R8 sample", d, smp_q.size() ? smp_q.pop_front() : 16'hDEAD);
        end
    endtask

    task automatic restart_lists();
        wr(2'd1, 16'h0000);
        wr(2'd1, 16'h0600);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd2, d); chk("R1 status", d, 16'h0004);
        chk("R1 irq", {15'h0, irq}, 16'h0);
        chk("R1 starts", 16'(starts), 16'h0);

        // software mode, list order and wrap
        wr(2'd1, 16'h0600);
        wr(2'd3, 16'h0003); wr(2'd3, 16'h002C); wr(2'd3, 16'h0045); wr(2'd3, 16'h0082);
        wr(2'd0, 16'h0001);
        expect_conv(8'h03); soft_trig();
        expect_conv(8'h2C); soft_trig();
        expect_conv(8'h45); soft_trig();
        expect_conv(8'h82); soft_trig();
        expect_conv(8'h03); soft_trig();   // R4 wrap
        expect_conv(8'h2C); soft_trig();
        drain(6);
        rd(2'd3, d); chk("R8 empty read", d, 16'h0000);

        // mode off: a mode-register read starts nothing
        wr(2'd0, 16'h0000);
        s0 = starts; soft_trig();
        chk("R3 off-mode read", 16'(starts), 16'(s0));

        // scan mode from position 2, pass-done flag and irq
        wr(2'd0, 16'h8402);
        expect_conv(8'h45); expect_conv(8'h82); expect_conv(8'h03); expect_conv(8'h2C);
        @(negedge clk); scan_trig = 1'b1; @(negedge clk); scan_trig = 1'b0;
        repeat (60) @(negedge clk);
        rd(2'd2, d); chk("R5 pass flag", d & 16'h0400, 16'h0400);
        chk("R12 irq set", {15'h0, irq}, 16'h1);
        drain(4);
        wr(2'd2, 16'h0000);
        rd(2'd2, d); chk("R12 status cleared", d & 16'h0760, 16'h0000);
        chk("R12 irq cleared", {15'h0, irq}, 16'h0);

        // flush
        expect_conv(8'h45);
        wr(2'd0, 16'h0001); soft_trig();
        wr(2'd1, 16'h0400);
        rd(2'd2, d); chk("R11 flushed", d & 16'h001E, 16'h0004);
        void'(smp_q.pop_front());
        wr(2'd1, 16'h0600);

        // invalid differential entries are skipped
        wr(2'd3, 16'h0089); wr(2'd3, 16'h0007); wr(2'd3, 16'h00C1); wr(2'd3, 16'h0001);
        s0 = starts;
        soft_trig();
        expect_conv(8'h07); soft_trig();
        soft_trig();
        expect_conv(8'h01); soft_trig();
        chk("R7 starts", 16'(starts - s0), 16'd2);
        rd(2'd2, d); chk("R7 skip flag", d & 16'h0040, 16'h0040);
        drain(2);

        // external mode, edge selection and ext flag
        restart_lists();
        wr(2'd3, 16'h0011); wr(2'd3, 16'h0022);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0203);
        s0 = starts;
        expect_conv(8'h11);
        @(negedge clk); ext_trig = 1'b1; settle();
        chk("R6 rising", 16'(starts - s0), 16'd1);
        rd(2'd2, d); chk("R14 ext flag", d & 16'h0200, 16'h0200);
        chk("R12 irq gated", {15'h0, irq}, 16'h0);
        @(negedge clk); ext_trig = 1'b0; settle();
        chk("R6 falling ignored", 16'(starts - s0), 16'd1);
        wr(2'd0, 16'h020B);
        @(negedge clk); ext_trig = 1'b1; settle();
        chk("R6 rising ignored", 16'(starts - s0), 16'd1);
        expect_conv(8'h22);
        @(negedge clk); ext_trig = 1'b0; settle();
        chk("R6 falling", 16'(starts - s0), 16'd2);
        drain(2);

        // half-full, full, overflow
        restart_lists();
        wr(2'd3, 16'h0005);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h8101);
        for (int i = 0; i < 16; i++) begin expect_conv(8'h05); soft_trig(); end
        rd(2'd2, d); chk("R9/R13 half", d & 16'h0118, 16'h0108);
        chk("R13 irq", {15'h0, irq}, 16'h1);
        for (int i = 0; i < 16; i++) begin expect_conv(8'h05); soft_trig(); end
        rd(2'd2, d); chk("R9 full", d & 16'h003C, 16'h0018);
        sel_q.push_back(8'h05); soft_trig();
        rd(2'd2, d); chk("R10 overflow", d & 16'h0030, 16'h0030);
        drain(32);
        rd(2'd3, d); chk("R10 dropped", d, 16'h0000);

        // channel list full
        restart_lists();
        for (int i = 0; i < 16; i++) wr(2'd3, 16'(i));
        rd(2'd2, d); chk("R9 list full", d & 16'h0002, 16'h0002);

        chk("scoreboard empty", 16'(sel_q.size() + smp_q.size()), 16'd0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule